// File: doc/BRIEF.md
# Cached Two-Level Page Translator

This block turns 32-bit virtual addresses into physical addresses. An 8-entry, fully associative translation cache sits in front of a two-level page table in memory. A request that hits the cache is answered on the next clock edge and makes no memory access.

A request that misses starts a walk. The walk makes two sequential reads, one for the outer entry and one for the inner entry. If both entries are valid, the translation is written into the cache and the response is returned. If either entry is invalid, the walk stops and the response reports a fault.

The root of the page table is loaded through a register-write port. A single-cycle flush input empties the cache. Only one translation is in progress at a time, and the request port deasserts ready while a walk is running. The response is a one-cycle pulse with no backpressure. The memory port issues single-cycle read pulses and accepts the read data whenever it arrives.

Top module: `pgxlat_top`

## Requirements
- R1: Virtual address bits [31:22] form the outer index, bits [21:12] the inner index and bits [11:0] the page offset. The outer entry is read at {base[31:12], outer index, 2'b00}. The inner entry is read at {outer entry[31:12], inner index, 2'b00}.
- R2: A page-table entry carries its frame number in bits [31:12] and its valid flag in bit 0 (1 = valid).
- R3: A request that hits the cache gets `rsp_valid` on the clock edge that accepts it. No memory read is made, and `rsp_paddr` = {cached frame, offset}.
- R4: A request that misses makes exactly two reads (outer, then inner). Its response gives `rsp_paddr` = {inner entry frame, offset} with `rsp_fault` low.
- R5: An outer entry with a clear valid flag ends the walk after one read. The response has `rsp_fault` high and `rsp_paddr` zero.
- R6: An inner entry with a clear valid flag ends the walk after two reads. The response has `rsp_fault` high and `rsp_paddr` zero.
- R7: A faulting walk installs nothing, so the same page walks again on its next request.
- R8: A successful walk installs its translation on the same edge that raises the response. Later requests to that page hit.
- R9: The cache holds 8 distinct pages and replaces them in round-robin order of installation.
- R10: A one-cycle `flush` pulse invalidates every cache entry. The next request to any page walks. A flush and a refill on the same edge leave the cache empty.
- R11: `req_ready` is low from the edge that accepts a missing request until the edge that returns its response. A hit leaves `req_ready` high.
- R12: A write on `base_we` loads the page-table base, which applies to every walk started afterwards.
- R13: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation failed on an invalid entry |
| mem_req_valid | output | 1 | One-cycle page-table read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Page-table entry read back |
| base_we | input | 1 | Load the page-table base |
| base_data | input | 32 | New base (bits [31:12] are kept) |
| flush | input | 1 | Invalidate all cache entries |

## Verification
The translation path is exercised with four patterns:
- repeated accesses to one page, which distinguish a hit from a walk;
- an address whose outer entry is invalid and one whose inner entry is invalid, which show where a faulting walk stops;
- nine distinct valid pages in a row, which expose the replacement order once the eighth slot is used;
- reuse after a flush and after a base change, which shows that stale translations are gone and that the new root steers the walk.

The number of memory reads and the stall on `req_ready` identify each case, alongside the translated address.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = VA_W - OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUT_REQ,
    ST_OUT_WAIT,
    ST_IN_REQ,
    ST_IN_WAIT
  } walk_state_e;
endpackage

// File: rtl/pgxlat_tlb.sv
module pgxlat_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             flush
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] wr_en;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  // Parallel compare and per-entry write enable
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn);
    assign wr_en[g]   = fill_en && !flush && (ptr_q == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_pfn = hit_pfn | (hit_vec[i] ? pfn_q[i] : '0);
    end
  end

  // Valid flags and round-robin pointer
  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (flush) begin
      valid_d = '0;
    end else if (fill_en) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : PTR_W'(ptr_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_TLB_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);                                          // R9
  AST_TLB_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));                                         // R10
  AST_TLB_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> valid_q[$past(ptr_q)]);                     // R8
endmodule

// File: rtl/pgxlat_walker.sv
module pgxlat_walker
  import pgxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic             lk_hit,
  input  logic [PFN_W-1:0] lk_pfn,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [VA_W-1:0]  mem_rsp_data,
  input  logic             base_we,
  input  logic [VA_W-1:0]  base_data,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn
);
  walk_state_e      state_q, state_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PFN_W-1:0] tbl_q, tbl_d;
  logic [PFN_W-1:0] root_q;
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_fault_q, rsp_fault_d;
  logic [VA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  logic             accept;
  logic             ld_req;
  logic             ld_tbl;
  logic             pte_ok;
  logic [IDX_W-1:0] outer_idx;
  logic [IDX_W-1:0] inner_idx;
  logic             unused_bits;

  assign unused_bits = ^{mem_rsp_data[OFF_W-1:1], base_data[OFF_W-1:0]};

  assign outer_idx = vpn_q[VPN_W-1 -: IDX_W];
  assign inner_idx = vpn_q[IDX_W-1:0];
  assign pte_ok    = mem_rsp_data[0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign fill_vpn = vpn_q;
  assign fill_pfn = mem_rsp_data[VA_W-1:OFF_W];

  // Next-state and response logic
  always_comb begin
    state_d     = state_q;
    vpn_d       = vpn_q;
    off_d       = off_q;
    tbl_d       = tbl_q;
    ld_req      = 1'b0;
    ld_tbl      = 1'b0;
    fill_en     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_fault_d = 1'b0;
    rsp_paddr_d = rsp_paddr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ld_req = 1'b1;
          vpn_d  = req_vaddr[VA_W-1:OFF_W];
          off_d  = req_vaddr[OFF_W-1:0];
          if (lk_hit) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = {lk_pfn, req_vaddr[OFF_W-1:0]};
          end else begin
            state_d = ST_OUT_REQ;
          end
        end
      end
      ST_OUT_REQ: state_d = ST_OUT_WAIT;
      ST_OUT_WAIT: begin
        if (mem_rsp_valid) begin
          if (pte_ok) begin
            ld_tbl  = 1'b1;
            tbl_d   = mem_rsp_data[VA_W-1:OFF_W];
            state_d = ST_IN_REQ;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_fault_d = 1'b1;
            rsp_paddr_d = '0;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_IN_REQ: state_d = ST_IN_WAIT;
      ST_IN_WAIT: begin
        if (mem_rsp_valid) begin
          rsp_valid_d = 1'b1;
          state_d     = ST_IDLE;
          if (pte_ok) begin
            fill_en     = 1'b1;
            rsp_paddr_d = {mem_rsp_data[VA_W-1:OFF_W], off_q};
          end else begin
            rsp_fault_d = 1'b1;
            rsp_paddr_d = '0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Page-table read port
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = {tbl_q, inner_idx, 2'b00};
    if (state_q == ST_OUT_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = {root_q, outer_idx, 2'b00};
    end else if (state_q == ST_IN_REQ) begin
      mem_req_valid = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      tbl_q       <= '0;
      root_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_paddr_q <= rsp_paddr_d;
      if (ld_req) begin
        vpn_q <= vpn_d;
        off_q <= off_d;
      end
      if (ld_tbl) begin
        tbl_q <= tbl_d;
      end
      if (base_we) begin
        root_q <= base_data[VA_W-1:OFF_W];
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_paddr = rsp_paddr_q;

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));                    // R5
  AST_HIT_ANSWERS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit) |=> (rsp_valid && !rsp_fault));                  // R3
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit) |=> !req_ready);                                // R11
  AST_READS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);                                  // R4
  AST_FILL_GOOD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rsp_valid && !rsp_fault));                             // R8
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
  import pgxlat_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        base_we,
  input  logic [31:0] base_data,
  input  logic        flush
);
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             fill_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  pgxlat_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) tlb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_vpn (req_vaddr[VA_W-1:OFF_W]),
    .hit        (lk_hit),
    .hit_pfn    (lk_pfn),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .flush      (flush)
  );

  pgxlat_walker walk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .lk_hit        (lk_hit),
    .lk_pfn        (lk_pfn),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_we       (base_we),
    .base_data     (base_data),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_pfn      (fill_pfn)
  );

  AST_STALL_NO_RSP_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> !rsp_valid);                  // R11
endmodule

// File: tb/pgxlat_top_tb_top.sv
`timescale 1ns/1ps
module pgxlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        base_we = 1'b0;
  logic [31:0] base_data = '0;
  logic        flush = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  int rd_cnt   = 0;
  int busy_cnt = 0;
  logic [19:0] root_frame = 20'h00100;
  bit          root_alt   = 1'b0;

  always #5 clk = ~clk;

  pgxlat_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_we       (base_we),
    .base_data     (base_data),
    .flush         (flush)
  );

  // Page-table contents, defined by rule (R1, R2)
  function automatic logic [31:0] pt_entry(input logic [31:0] addr);
    int idx;
    int frame;
    idx = int'(addr[11:2]);
    if (addr[31:12] == root_frame) begin
      frame = 'h200 + idx + (root_alt ? 'h100 : 0);
      return {20'(frame), 11'd0, (idx % 3) != 2};
    end
    frame = (int'(addr[31:12]) * 7 + idx) & 'hFFFFF;
    return {20'(frame), 11'd0, (idx % 5) != 4};
  endfunction

  // Expected {fault, paddr} from the requirements
  function automatic logic [32:0] model_xlat(input logic [31:0] va);
    int oi;
    int ii;
    int tbl;
    int frame;
    oi = int'(va[31:22]);
    ii = int'(va[21:12]);
    if ((oi % 3) == 2) return {1'b1, 32'd0};
    tbl = 'h200 + oi + (root_alt ? 'h100 : 0);
    if ((ii % 5) == 4) return {1'b1, 32'd0};
    frame = (tbl * 7 + ii) & 'hFFFFF;
    return {1'b0, 20'(frame), va[11:0]};
  endfunction

  // Memory with two cycles of read latency
  logic        m_d1 = 1'b0;
  logic        m_d2 = 1'b0;
  logic [31:0] m_a1 = '0;
  logic [31:0] m_q2 = '0;
  always @(posedge clk) begin
    m_d1 <= mem_req_valid;
    m_a1 <= mem_req_addr;
    m_d2 <= m_d1;
    m_q2 <= pt_entry(m_a1);
    if (mem_req_valid) rd_cnt <= rd_cnt + 1;
    if (rst_n && !req_ready) busy_cnt <= busy_cnt + 1;
  end
  assign mem_rsp_valid = m_d2;
  assign mem_rsp_data  = m_q2;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic run_xlat(input logic [31:0] va, input int exp_reads);
    logic [32:0] e;
    int r0;
    int b0;
    int waited;
    string tag;
    e  = model_xlat(va);
    r0 = rd_cnt;
    b0 = busy_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (exp_reads == 0)      tag = "R3 hit";
    else if (!e[32])         tag = "R4 R1 walk";
    else if (exp_reads == 1) tag = "R5 outer fault";
    else                     tag = "R6 inner fault";
    check(rsp_valid == 1'b1, {tag, " response"}, 64'(rsp_valid), 64'd1);
    check({rsp_fault, rsp_paddr} == e, tag, 64'({rsp_fault, rsp_paddr}), 64'(e));
    check((rd_cnt - r0) == exp_reads, "R8 R9 R7 read count",
          64'(rd_cnt - r0), 64'(exp_reads));
    check(((busy_cnt - b0) > 0) == (exp_reads > 0), "R11 ready stall",
          64'(busy_cnt - b0), 64'(exp_reads > 0));
  endtask

  // {vaddr, expected memory reads}
  localparam int NV = 19;
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_1ABC, 4'd2},   // first touch of page (0,1)      R4
    {32'h0000_1FFF, 4'd0},   // same page hits                  R8 R3
    {32'h0080_0123, 4'd1},   // outer invalid                   R5
    {32'h0000_4010, 4'd2},   // inner invalid                   R6
    {32'h0040_5555, 4'd2},   // page (1,5)                      R4
    {32'h0000_1000, 4'd0},   // hit                             R3
    {32'h0080_0000, 4'd1},   // fault not cached                R7
    {32'h0000_2000, 4'd2},   // fill slots 2..7                 R9
    {32'h0000_3004, 4'd2},
    {32'h0000_5008, 4'd2},
    {32'h0000_600C, 4'd2},
    {32'h0000_7010, 4'd2},
    {32'h0000_8014, 4'd2},
    {32'h0000_1020, 4'd0},   // all 8 resident                  R9
    {32'h0040_5000, 4'd0},
    {32'h0000_A000, 4'd2},   // evicts slot 0 (0,1)             R9
    {32'h0000_1030, 4'd2},   // (0,1) gone, evicts (1,5)        R9
    {32'h0040_5AAA, 4'd2},   // (1,5) gone, evicts (0,2)        R9
    {32'h0000_3FFF, 4'd0}    // (0,3) still resident            R9
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check(req_ready == 1'b1, "R13 ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R13 rsp", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R13 mem", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    base_we   = 1'b1;
    base_data = 32'h0010_0ABC;   // low bits ignored, R12
    @(negedge clk);
    base_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_xlat(VEC[i][35:4], int'(VEC[i][3:0]));
    end

    // R10 flush empties the cache
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    run_xlat(32'h0000_3FFF, 2);
    run_xlat(32'h0000_A123, 2);
    run_xlat(32'h0000_A456, 0);

    // R12 new base steers later walks
    @(negedge clk);
    base_we   = 1'b1;
    base_data = 32'h0070_0000;
    @(negedge clk);
    base_we    = 1'b0;
    root_frame = 20'h00700;
    root_alt   = 1'b1;
    flush      = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    run_xlat(32'h0000_1ABC, 2);
    run_xlat(32'h0040_7001, 2);
    run_xlat(32'h0080_7001, 1);
    run_xlat(32'h0000_1ABD, 0);

    // R13 reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R13 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    base_we   = 1'b1;
    base_data = 32'h0070_0000;
    @(negedge clk);
    base_we = 1'b0;
    run_xlat(32'h0000_1ABC, 2);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule